// File: doc/BRIEF.md
# Storage Port Command and Control Register

This block is the command and control register of one port in a serial-storage host adapter, together with the logic that acts when its fields are written. Software writes a full word through a single write strobe and reads the current value back combinationally. Several fields do more than store a value. Raising the run field tells the command engine to start at slot 0. Lowering it clears the command-issue register, but only once the engine reports idle. Raising the spin-up field asks the link for one initialization sequence. Writing 1 to the override field pulses a clear of the device busy and data-request status bits, and the field stays set until hardware sees both bits low.

A receive-enable field allows received frames to be posted. A read-only running flag follows that field, and it drops only when the receive path is idle. While receive is disabled, the block still accepts the first device-to-host register frame that arrives after a link initialization request. The spin-up field is writable only when the staggered-spin-up strap is 1. When the strap is 0 the field reads as a fixed 1.

Top module: `portCmdCtl`

## Requirements
- R1: While `rst` is high and in the cycle after it falls with no write, `rdData` is 0x00000004 when `capStagger` is 1 and 0x00000006 when it is 0. All pulse outputs, `cmdFetchEn` and `rxPostEn` are 0.
- R2: Bit 0 (run) is read/write and drives `cmdFetchEn`. A write that takes it from 0 to 1 makes `startAtSlot0` high for the single cycle after the write edge. Writing 1 while it is already 1 gives no pulse.
- R3: A write that takes bit 0 from 1 to 0 produces exactly one `clearCmdIssue` pulse. The pulse comes in the cycle after the first clock edge, at or after the write edge, at which `engineIdle` is 1.
- R4: With `capStagger`=1, bit 1 (spin-up) is read/write and resets to 0. A 0-to-1 write makes `linkInitReq` high for the single cycle after the write edge. Writing 1 while it is already 1 gives no request.
- R5: With `capStagger`=0, bit 1 reads 1, writes to it are ignored and `linkInitReq` never rises.
- R6: Bit 2 always reads 1. Bits 5 to 13 and 15 and above read 0 and ignore writes, and bit 14 ignores writes.
- R7: A write with bit 3 (override) at 1 sets bit 3 and makes `clearBusyDrq` high for the cycle after the write edge. Bit 3 then reads 1 until an edge at which `tfdBusy` and `tfdDrq` are both 0, and reads 0 after that edge. A write with bit 3 at 0 leaves bit 3 unchanged.
- R8: Bit 4 (receive enable) is read/write and drives `rxPostEn`. While it is 1, `frameAccept` equals `frameValid`.
- R9: While bit 4 is 0, `frameAccept` is 1 only for a frame with `frameValid` and `frameIsD2h` both 1, arriving after a `linkInitReq` pulse and before any earlier device-to-host frame. After the first such frame is seen, later ones are rejected.
- R10: Bit 14 (receive running) reads 1 from the edge after an edge where bit 4 is 1. It reads 0 from the edge after an edge where bit 4 is 0 and `rxIdle` is 1. Otherwise it holds.
- R11: `startAtSlot0`, `linkInitReq`, `clearBusyDrq` and `clearCmdIssue` last one cycle for each triggering event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| capStagger | input | 1 | Staggered spin-up capability strap |
| wrEn | input | 1 | Register write strobe |
| wrData | input | REG_W | Register write data |
| rdData | output | REG_W | Register read data |
| tfdBusy | input | 1 | Device task-file busy status |
| tfdDrq | input | 1 | Device task-file data-request status |
| engineIdle | input | 1 | Command engine has reached idle |
| rxIdle | input | 1 | Receive path is idle |
| frameValid | input | 1 | A received frame is offered this cycle |
| frameIsD2h | input | 1 | Offered frame is a device-to-host register frame |
| frameAccept | output | 1 | Offered frame may be posted |
| startAtSlot0 | output | 1 | Pulse: begin command list at slot 0 |
| linkInitReq | output | 1 | Pulse: request link initialization |
| clearBusyDrq | output | 1 | Pulse: clear busy and data-request status |
| clearCmdIssue | output | 1 | Pulse: clear the command-issue register |
| cmdFetchEn | output | 1 | Command-list processing enabled |
| rxPostEn | output | 1 | Received-frame posting enabled |

## Verification
The assertions assume that `capStagger` is a strap held constant from reset onward, and that every status input carries a known value on every clock edge. The bench reapplies reset before it changes the strap. It drives each input to 0 or 1 at the falling edge, so no input is ever unknown or changing at a rising edge. The bench never writes the override bit outside a run-field sequence in a way that the property on the override release could misread, because that release depends only on the two status inputs, which the bench always drives.

// File: rtl/portCmdPkg.sv
package portCmdPkg;
  localparam int RUN_BIT   = 0;
  localparam int SPIN_BIT  = 1;
  localparam int POWER_BIT = 2;
  localparam int OVR_BIT   = 3;
  localparam int RXEN_BIT  = 4;
  localparam int RXRUN_BIT = 14;
  localparam int PULSE_N   = 4;

  typedef struct packed {
    logic loadRun;
    logic runRise;
    logic loadSpin;
    logic spinRise;
    logic ovrSet;
    logic ovrRelease;
    logic loadRxEn;
    logic rxRunSet;
    logic rxRunClr;
    logic ciClr;
    logic stopHold;
    logic d2hArm;
    logic d2hSeen;
  } ctlStrobes_t;
endpackage

// File: rtl/portCmdCtrl.sv
module portCmdCtrl
  import portCmdPkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             capStagger,
  input  logic             runQ,
  input  logic             spinQ,
  input  logic             ovrQ,
  input  logic             rxEnQ,
  input  logic             stopPendQ,
  input  logic             tfdBusy,
  input  logic             tfdDrq,
  input  logic             engineIdle,
  input  logic             rxIdle,
  input  logic             frameValid,
  input  logic             frameIsD2h,
  output ctlStrobes_t      strobes
);
  logic runFall;
  logic unusedWrBits;

  assign unusedWrBits = ^{wrData[REG_W-1:RXEN_BIT+1], wrData[POWER_BIT]};

  always_comb begin
    strobes          = '0;
    strobes.loadRun  = wrEn;
    strobes.runRise  = wrEn && wrData[RUN_BIT] && !runQ;
    runFall          = wrEn && !wrData[RUN_BIT] && runQ;
    strobes.loadSpin = wrEn && capStagger;
    strobes.spinRise = wrEn && capStagger && wrData[SPIN_BIT] && !spinQ;
    strobes.ovrSet   = wrEn && wrData[OVR_BIT];
    strobes.ovrRelease = ovrQ && !tfdBusy && !tfdDrq;
    strobes.loadRxEn = wrEn;
    strobes.rxRunSet = rxEnQ;
    strobes.rxRunClr = !rxEnQ && rxIdle;
    strobes.ciClr    = ((stopPendQ && !strobes.runRise) || runFall) && engineIdle;
    strobes.stopHold = ((stopPendQ && !strobes.runRise) || runFall) && !engineIdle;
    strobes.d2hArm   = strobes.spinRise;
    strobes.d2hSeen  = frameValid && frameIsD2h;
  end
endmodule

// File: rtl/portCmdRegs.sv
module portCmdRegs
  import portCmdPkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capStagger,
  input  logic [REG_W-1:0] wrData,
  input  ctlStrobes_t      strobes,
  input  logic             tfdBusy,
  input  logic             tfdDrq,
  input  logic             engineIdle,
  input  logic             rxIdle,
  input  logic             frameValid,
  input  logic             frameIsD2h,
  output logic             runQ,
  output logic             spinQ,
  output logic             ovrQ,
  output logic             rxEnQ,
  output logic             stopPendQ,
  output logic [REG_W-1:0] rdData,
  output logic [PULSE_N-1:0] pulses,
  output logic             frameAccept
);
  logic rxRunQ;
  logic d2hPendQ;
  logic [PULSE_N-1:0] pulseReq;

  always_ff @(posedge clk) begin
    if (rst) begin
      runQ      <= 1'b0;
      spinQ     <= 1'b0;
      ovrQ      <= 1'b0;
      rxEnQ     <= 1'b0;
      rxRunQ    <= 1'b0;
      stopPendQ <= 1'b0;
      d2hPendQ  <= 1'b0;
    end else begin
      if (strobes.loadRun)  runQ  <= wrData[RUN_BIT];
      if (strobes.loadSpin) spinQ <= wrData[SPIN_BIT];
      if (strobes.loadRxEn) rxEnQ <= wrData[RXEN_BIT];
      if (strobes.ovrSet)          ovrQ <= 1'b1;
      else if (strobes.ovrRelease) ovrQ <= 1'b0;
      if (strobes.rxRunSet)      rxRunQ <= 1'b1;
      else if (strobes.rxRunClr) rxRunQ <= 1'b0;
      stopPendQ <= strobes.stopHold;
      if (strobes.d2hArm)       d2hPendQ <= 1'b1;
      else if (strobes.d2hSeen) d2hPendQ <= 1'b0;
    end
  end

  // pulse order: start, link init, clear busy/drq, clear command issue
  assign pulseReq = {strobes.ciClr, strobes.ovrSet, strobes.spinRise, strobes.runRise};

  for (genvar i = 0; i < PULSE_N; i++) begin : g_pulse
    always_ff @(posedge clk) begin
      if (rst) pulses[i] <= 1'b0;
      else     pulses[i] <= pulseReq[i];
    end
  end

  always_comb begin
    rdData            = '0;
    rdData[RUN_BIT]   = runQ;
    rdData[SPIN_BIT]  = capStagger ? spinQ : 1'b1;
    rdData[POWER_BIT] = 1'b1;
    rdData[OVR_BIT]   = ovrQ;
    rdData[RXEN_BIT]  = rxEnQ;
    rdData[RXRUN_BIT] = rxRunQ;
  end

  assign frameAccept = frameValid && (rxEnQ || (frameIsD2h && d2hPendQ));

  p_start_edge_r2: assert property (@(posedge clk) disable iff (rst)
    pulses[0] |-> (runQ && !$past(runQ)));
  p_ci_after_idle_r3: assert property (@(posedge clk) disable iff (rst)
    pulses[3] |-> ($past(engineIdle) && !runQ));
  p_link_edge_r4: assert property (@(posedge clk) disable iff (rst)
    pulses[1] |-> (spinQ && !$past(spinQ)));
  p_strap_off_r5: assert property (@(posedge clk) disable iff (rst)
    !capStagger |-> !pulses[1]);
  p_ovr_release_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(ovrQ) |-> $past(!tfdBusy && !tfdDrq));
  p_rxrun_drop_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(rxRunQ) |-> $past(!rxEnQ && rxIdle));
  p_rxrun_rise_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(rxRunQ) |-> $past(rxEnQ));
  p_start_once_r11: assert property (@(posedge clk) disable iff (rst)
    pulses[0] |=> !pulses[0]);
  p_link_once_r11: assert property (@(posedge clk) disable iff (rst)
    pulses[1] |=> !pulses[1]);
endmodule

// File: rtl/portCmdCtl.sv
module portCmdCtl
  import portCmdPkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capStagger,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic             tfdBusy,
  input  logic             tfdDrq,
  input  logic             engineIdle,
  input  logic             rxIdle,
  input  logic             frameValid,
  input  logic             frameIsD2h,
  output logic             frameAccept,
  output logic             startAtSlot0,
  output logic             linkInitReq,
  output logic             clearBusyDrq,
  output logic             clearCmdIssue,
  output logic             cmdFetchEn,
  output logic             rxPostEn
);
  ctlStrobes_t strobes;
  logic runQ, spinQ, ovrQ, rxEnQ, stopPendQ;
  logic [PULSE_N-1:0] pulses;

  portCmdCtrl #(.REG_W(REG_W)) uCtrl (
    .wrEn(wrEn), .wrData(wrData), .capStagger(capStagger),
    .runQ(runQ), .spinQ(spinQ), .ovrQ(ovrQ), .rxEnQ(rxEnQ),
    .stopPendQ(stopPendQ), .tfdBusy(tfdBusy), .tfdDrq(tfdDrq),
    .engineIdle(engineIdle), .rxIdle(rxIdle), .frameValid(frameValid),
    .frameIsD2h(frameIsD2h), .strobes(strobes)
  );

  portCmdRegs #(.REG_W(REG_W)) uRegs (
    .clk(clk), .rst(rst), .capStagger(capStagger), .wrData(wrData),
    .strobes(strobes), .tfdBusy(tfdBusy), .tfdDrq(tfdDrq),
    .engineIdle(engineIdle), .rxIdle(rxIdle), .frameValid(frameValid),
    .frameIsD2h(frameIsD2h), .runQ(runQ), .spinQ(spinQ), .ovrQ(ovrQ),
    .rxEnQ(rxEnQ), .stopPendQ(stopPendQ), .rdData(rdData),
    .pulses(pulses), .frameAccept(frameAccept)
  );

  assign startAtSlot0  = pulses[0];
  assign linkInitReq   = pulses[1];
  assign clearBusyDrq  = pulses[2];
  assign clearCmdIssue = pulses[3];
  assign cmdFetchEn    = runQ;
  assign rxPostEn      = rxEnQ;
endmodule

// File: tb/portCmdCtl_test.sv
module portCmdCtl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic capStagger = 1'b1;
  logic wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic tfdBusy = 1'b0, tfdDrq = 1'b0, engineIdle = 1'b0, rxIdle = 1'b1;
  logic frameValid = 1'b0, frameIsD2h = 1'b0;
  logic frameAccept, startAtSlot0, linkInitReq, clearBusyDrq, clearCmdIssue;
  logic cmdFetchEn, rxPostEn;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  portCmdCtl uut (
    .clk(clk), .rst(rst), .capStagger(capStagger), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .tfdBusy(tfdBusy), .tfdDrq(tfdDrq),
    .engineIdle(engineIdle), .rxIdle(rxIdle), .frameValid(frameValid),
    .frameIsD2h(frameIsD2h), .frameAccept(frameAccept),
    .startAtSlot0(startAtSlot0), .linkInitReq(linkInitReq),
    .clearBusyDrq(clearBusyDrq), .clearCmdIssue(clearCmdIssue),
    .cmdFetchEn(cmdFetchEn), .rxPostEn(rxPostEn)
  );

  typedef struct packed {
    logic        we;
    logic [31:0] wd;
    logic        busy;
    logic        drq;
    logic        idle;
    logic        rxi;
    logic [31:0] expRd;
    logic [3:0]  expP; // {start, link, clrBusy, clrCi}
  } vec_t;

  localparam int NVEC = 24;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 32'h1,         1'b0, 1'b0, 1'b0, 1'b1, 32'h5,    4'b1000}, // R2 rise
    '{1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 1'b1, 32'h5,    4'b0000}, // R11
    '{1'b1, 32'h1,         1'b0, 1'b0, 1'b0, 1'b1, 32'h5,    4'b0000}, // R2 rewrite
    '{1'b1, 32'h0,         1'b0, 1'b0, 1'b0, 1'b1, 32'h4,    4'b0000}, // R3 stop, busy engine
    '{1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 1'b1, 32'h4,    4'b0000}, // R3 wait
    '{1'b0, 32'h0,         1'b0, 1'b0, 1'b1, 1'b1, 32'h4,    4'b0001}, // R3 idle
    '{1'b0, 32'h0,         1'b0, 1'b0, 1'b1, 1'b1, 32'h4,    4'b0000}, // R11
    '{1'b1, 32'h2,         1'b0, 1'b0, 1'b0, 1'b1, 32'h6,    4'b0100}, // R4 rise
    '{1'b1, 32'h2,         1'b0, 1'b0, 1'b0, 1'b1, 32'h6,    4'b0000}, // R4 rewrite
    '{1'b1, 32'hA,         1'b1, 1'b0, 1'b0, 1'b1, 32'hE,    4'b0010}, // R7 set
    '{1'b0, 32'h0,         1'b1, 1'b0, 1'b0, 1'b1, 32'hE,    4'b0000}, // R7 busy
    '{1'b0, 32'h0,         1'b0, 1'b1, 1'b0, 1'b1, 32'hE,    4'b0000}, // R7 drq
    '{1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 1'b1, 32'h6,    4'b0000}, // R7 release
    '{1'b1, 32'h2,         1'b1, 1'b0, 1'b0, 1'b1, 32'h6,    4'b0000}, // R7 write 0
    '{1'b1, 32'h12,        1'b0, 1'b0, 1'b0, 1'b0, 32'h16,   4'b0000}, // R8 enable
    '{1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 32'h4016, 4'b0000}, // R10 set
    '{1'b1, 32'h2,         1'b0, 1'b0, 1'b0, 1'b0, 32'h4006, 4'b0000}, // R10 hold
    '{1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 32'h4006, 4'b0000}, // R10 hold
    '{1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 1'b1, 32'h6,    4'b0000}, // R10 drop
    '{1'b1, 32'hFFFF_BFE2, 1'b0, 1'b0, 1'b0, 1'b1, 32'h6,    4'b0000}, // R6
    '{1'b1, 32'h0,         1'b0, 1'b0, 1'b0, 1'b1, 32'h4,    4'b0000}, // R4 clear
    '{1'b1, 32'h2,         1'b0, 1'b0, 1'b0, 1'b1, 32'h6,    4'b0100}, // R4 again
    '{1'b1, 32'h3,         1'b0, 1'b0, 1'b0, 1'b1, 32'h7,    4'b1000}, // R2
    '{1'b1, 32'h2,         1'b0, 1'b0, 1'b1, 1'b1, 32'h6,    4'b0001}  // R3 idle at write
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset(input logic cap);
    @(negedge clk);
    rst = 1'b1; capStagger = cap; wrEn = 1'b0; wrData = '0;
    tfdBusy = 1'b0; tfdDrq = 1'b0; engineIdle = 1'b0; rxIdle = 1'b1;
    frameValid = 1'b0; frameIsD2h = 1'b0;
    step(); step();
    rst = 1'b0;
  endtask

  function automatic logic [3:0] pulsesNow();
    return {startAtSlot0, linkInitReq, clearBusyDrq, clearCmdIssue};
  endfunction

  initial begin
    doReset(1'b1);
    step();
    chk("R1 rdData cap=1", rdData, 32'h4);
    chk("R1 outputs", {28'h0, pulsesNow()} | {30'h0, cmdFetchEn, rxPostEn}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      wrEn = VECS[i].we; wrData = VECS[i].wd; tfdBusy = VECS[i].busy;
      tfdDrq = VECS[i].drq; engineIdle = VECS[i].idle; rxIdle = VECS[i].rxi;
      step();
      chk($sformatf("table %0d rdData (R2 R3 R4 R6 R7 R10)", i), rdData, VECS[i].expRd);
      chk($sformatf("table %0d pulses (R2 R3 R4 R7 R11)", i), {28'h0, pulsesNow()},
          {28'h0, VECS[i].expP});
    end
    wrEn = 1'b0;
    chk("R2 cmdFetchEn follows run bit", {31'h0, cmdFetchEn}, 32'h0);

    // receive enable and first device-to-host frame exception
    doReset(1'b1);
    frameValid = 1'b1; frameIsD2h = 1'b1;
    #1 chk("R9 no exception before link init", {31'h0, frameAccept}, 32'h0);
    frameValid = 1'b0;
    wrEn = 1'b1; wrData = 32'h2;
    step();
    wrEn = 1'b0;
    chk("R4 link request", {31'h0, linkInitReq}, 32'h1);
    frameValid = 1'b1; frameIsD2h = 1'b0;
    #1 chk("R9 other frame rejected", {31'h0, frameAccept}, 32'h0);
    frameIsD2h = 1'b1;
    #1 chk("R9 first D2H accepted", {31'h0, frameAccept}, 32'h1);
    step();
    chk("R9 second D2H rejected", {31'h0, frameAccept}, 32'h0);
    frameValid = 1'b0;
    wrEn = 1'b1; wrData = 32'h12;
    step();
    wrEn = 1'b0;
    chk("R8 rxPostEn", {31'h0, rxPostEn}, 32'h1);
    frameValid = 1'b1; frameIsD2h = 1'b0;
    #1 chk("R8 frame accepted when enabled", {31'h0, frameAccept}, 32'h1);
    frameValid = 1'b0;
    #1 chk("R8 no frame no accept", {31'h0, frameAccept}, 32'h0);

    // strap off
    doReset(1'b0);
    step();
    chk("R1 rdData cap=0", rdData, 32'h6);
    wrEn = 1'b1; wrData = 32'h0;
    step();
    chk("R5 spin bit fixed", rdData, 32'h6);
    wrData = 32'h2;
    step();
    wrEn = 1'b0;
    chk("R5 no link request", {31'h0, linkInitReq}, 32'h0);
    chk("R5 rdData", rdData, 32'h6);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule